// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs a successive-approximation converter with a 14-bit parallel output from the host side. While its enable input is high, it drives the converter's active-low start strobe at a fixed sample rate. The strobe's falling edge both starts a conversion and sets the sampling instant. The block releases the strobe early, well inside the window in which the converter tolerates a release. It then waits for the converter's BUSY line to return high.

Once BUSY has risen and a settle delay has passed, the block reads the data bus. The new word appears on two outputs: a 14-bit two's complement copy and a 16-bit sign-extended copy, both marked by a one-cycle valid pulse. One LSB of that word is 5 V / 16384.

All analog timing figures are given as system-clock cycle counts through parameters. If BUSY stays low too long, the block raises a timeout pulse and goes back to waiting. It never starts a new conversion while the converter still reports BUSY low.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the start strobe is high (inactive), and the valid and timeout outputs are low.
- R2: While `enable_i` is low, no falling edge of the start strobe is issued.
- R3: Each start pulse holds the strobe low for exactly `STRB_LOW_CYC` clock cycles. This is never more than `STRB_REL_CYC` cycles, the release deadline after the conversion start.
- R4: No falling strobe edge occurs while the synchronized BUSY is low. BUSY passes through two flops. A new start comes, at the earliest, on the third clock edge counting the first edge that samples BUSY high.
- R5: The data bus is captured on the `CAPT_MIN_CYC`-th clock edge after the first edge that samples BUSY high. The raw output equals the bus value present at that time.
- R6: Each completed conversion gives exactly one `sample_valid_o` pulse, one cycle long.
- R7: `sample_sext_o` is the 14-bit word with bit 13 copied into the two upper bits. For example, 0x2000 gives 0xE000 and 0x1FFF gives 0x1FFF.
- R8: When conversions finish early enough, successive falling strobe edges are exactly `PERIOD_CYC` cycles apart.
- R9: When a conversion outlasts the period, the next start follows on the clock edge after the capture edge.
- R10: If a conversion lasts `TIMEOUT_CYC` cycles from its start edge without a BUSY rise, `conv_timeout_o` pulses for one cycle on that edge. No valid is produced, and a later BUSY rise from that conversion gives no sample. Sampling then resumes once BUSY is high.
- R11: Dropping `enable_i` during a conversion lets that conversion complete and deliver its sample, and no further start follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Continuous sampling enable |
| adc_busy_i | input | 1 | Converter BUSY, low during a conversion |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| conv_start_n_o | output | 1 | Active-low conversion start strobe |
| sample_valid_o | output | 1 | One-cycle pulse marking a new sample |
| sample_raw_o | output | DATA_W | Captured two's complement word |
| sample_sext_o | output | OUT_W | Sign-extended captured word |
| conv_timeout_o | output | 1 | One-cycle pulse when BUSY fails to rise in time |

## Verification
The converter stub places a dummy pattern on the bus while BUSY is low and the real word only at the rise. A capture taken too early therefore shows the wrong value, and the measured rise-to-valid latency distinguishes each shift of the settle delay.

Short conversions expose the fixed start-to-start period. Long ones expose the stretch that follows capture. A stuck-low BUSY separates the timeout path from a normal completion and shows that no start is issued during the hang.

Words at both sign boundaries and at the extremes check the extension. Dropping enable in the middle of a conversion distinguishes finishing the current conversion from aborting it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STROBE = 2'd1,
        ST_CONV   = 2'd2,
        ST_CAPT   = 2'd3
    } seq_state_e;

    // Flops between the BUSY pin and its usable synchronized copy
    localparam int SYNC_LAT = 2;

endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
    parameter int STAGES = adc_seq_pkg::SYNC_LAT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_raw_i,
    output logic busy_s_o,
    output logic busy_rise_o
);

    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sh   = {s_q.sh[STAGES-2:0], busy_raw_i};
        s_d.prev = s_q.sh[STAGES-1];
    end

    // Idle converter reports BUSY high, so reset to high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sh   <= '1;
            s_q.prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_s_o    = s_q.sh[STAGES-1];
    assign busy_rise_o = s_q.sh[STAGES-1] & ~s_q.prev;

endmodule

// File: rtl/adc_rate_tick.sv
module adc_rate_tick #(
    parameter int PERIOD_CYC = 46
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ready_o
);

    localparam int CW = $clog2(PERIOD_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } rate_t;

    rate_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.cnt = CW'(PERIOD_CYC - 1);
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o = (r_q.cnt == '0);

    AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> ready_o); // R8

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 14,
    parameter int STRB_LOW_CYC = 5,
    parameter int STRB_REL_CYC = 22,
    parameter int CAPT_WAIT    = 1,
    parameter int TIMEOUT_CYC  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              ready_i,
    input  logic              busy_s_i,
    input  logic              busy_rise_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              start_o,
    output logic              strobe_n_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              timeout_o
);

    localparam int PH_MAX = (STRB_LOW_CYC > CAPT_WAIT) ? STRB_LOW_CYC : CAPT_WAIT;
    localparam int PHW    = $clog2(PH_MAX + 1);
    localparam int TMOW   = $clog2(TIMEOUT_CYC + 1);
    localparam int LRW    = $clog2(STRB_REL_CYC + 2);

    typedef struct packed {
        seq_state_e        state;
        logic [PHW-1:0]    ph;
        logic [TMOW-1:0]   tmo;
        logic              strobe_n;
        logic              valid;
        logic              err;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t f_d, f_q;

    always_comb begin
        f_d       = f_q;
        f_d.valid = 1'b0;
        f_d.err   = 1'b0;
        start_o   = 1'b0;
        case (f_q.state)
            ST_IDLE: begin
                if (enable_i && ready_i && busy_s_i) begin
                    start_o      = 1'b1;
                    f_d.state    = ST_STROBE;
                    f_d.strobe_n = 1'b0;
                    f_d.ph       = PHW'(1);
                    f_d.tmo      = TMOW'(1);
                end
            end
            ST_STROBE: begin
                f_d.tmo = f_q.tmo + 1'b1;
                if (f_q.ph == PHW'(STRB_LOW_CYC)) begin
                    f_d.strobe_n = 1'b1;
                    f_d.state    = ST_CONV;
                end else begin
                    f_d.ph = f_q.ph + 1'b1;
                end
            end
            ST_CONV: begin
                f_d.tmo = f_q.tmo + 1'b1;
                if (busy_rise_i) begin
                    f_d.state = ST_CAPT;
                    f_d.ph    = PHW'(1);
                end else if (f_q.tmo == TMOW'(TIMEOUT_CYC)) begin
                    f_d.err   = 1'b1;
                    f_d.state = ST_IDLE;
                end
            end
            ST_CAPT: begin
                if (f_q.ph == PHW'(CAPT_WAIT)) begin
                    f_d.data  = adc_data_i;
                    f_d.valid = 1'b1;
                    f_d.state = ST_IDLE;
                end else begin
                    f_d.ph = f_q.ph + 1'b1;
                end
            end
            default: f_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.state    <= ST_IDLE;
            f_q.ph       <= '0;
            f_q.tmo      <= '0;
            f_q.strobe_n <= 1'b1;
            f_q.valid    <= 1'b0;
            f_q.err      <= 1'b0;
            f_q.data     <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign strobe_n_o = f_q.strobe_n;
    assign valid_o    = f_q.valid;
    assign data_o     = f_q.data;
    assign timeout_o  = f_q.err;

    // Length of the current strobe-low run, kept for the checks below
    logic [LRW-1:0] low_run_d, low_run_q;

    always_comb begin
        if (f_q.strobe_n) begin
            low_run_d = '0;
        end else if (low_run_q == '1) begin
            low_run_d = low_run_q;
        end else begin
            low_run_d = low_run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_run_q <= '0;
        else        low_run_q <= low_run_d;
    end

    AST_STRB_DEADLINE: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= LRW'(STRB_REL_CYC)); // R3
    AST_STRB_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.strobe_n) |-> (low_run_q >= LRW'(STRB_LOW_CYC))); // R3
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(f_q.strobe_n) |-> $past(busy_s_i)); // R4
    AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(f_q.strobe_n) |-> $past(enable_i)); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.valid |=> !f_q.valid); // R6
    AST_TMO_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.err |-> !f_q.valid); // R10

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W       = 14,
    parameter int OUT_W        = 16,
    parameter int STRB_LOW_CYC = 5,
    parameter int STRB_REL_CYC = 22,
    parameter int CAPT_MIN_CYC = 3,
    parameter int PERIOD_CYC   = 46,
    parameter int TIMEOUT_CYC  = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              adc_busy_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              conv_start_n_o,
    output logic              sample_valid_o,
    output logic [DATA_W-1:0] sample_raw_o,
    output logic [OUT_W-1:0]  sample_sext_o,
    output logic              conv_timeout_o
);

    // Synchronizer flops count toward the capture delay
    localparam int CAPT_WAIT = (CAPT_MIN_CYC > SYNC_LAT + 1) ? (CAPT_MIN_CYC - SYNC_LAT) : 1;
    localparam int EXT_W     = OUT_W - DATA_W;

    logic busy_s, busy_rise, start, ready;

    adc_busy_sync #(.STAGES(SYNC_LAT)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_raw_i (adc_busy_i),
        .busy_s_o   (busy_s),
        .busy_rise_o(busy_rise)
    );

    adc_rate_tick #(.PERIOD_CYC(PERIOD_CYC)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start),
        .ready_o(ready)
    );

    adc_seq_fsm #(
        .DATA_W      (DATA_W),
        .STRB_LOW_CYC(STRB_LOW_CYC),
        .STRB_REL_CYC(STRB_REL_CYC),
        .CAPT_WAIT   (CAPT_WAIT),
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable_i),
        .ready_i    (ready),
        .busy_s_i   (busy_s),
        .busy_rise_i(busy_rise),
        .adc_data_i (adc_data_i),
        .start_o    (start),
        .strobe_n_o (conv_start_n_o),
        .valid_o    (sample_valid_o),
        .data_o     (sample_raw_o),
        .timeout_o  (conv_timeout_o)
    );

    generate
        if (EXT_W > 0) begin : g_ext
            assign sample_sext_o = {{EXT_W{sample_raw_o[DATA_W-1]}}, sample_raw_o};
        end else begin : g_trunc
            assign sample_sext_o = sample_raw_o[OUT_W-1:0];
        end
    endgenerate

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;

    localparam int CLK_PERIOD   = 10;
    localparam int DATA_W       = 14;
    localparam int OUT_W        = 16;
    localparam int STRB_LOW_CYC = 5;
    localparam int STRB_REL_CYC = 22;
    localparam int CAPT_MIN_CYC = 3;
    localparam int PERIOD_CYC   = 46;
    localparam int TIMEOUT_CYC  = 60;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b0;
    logic              busy = 1'b1;
    logic [DATA_W-1:0] bus = '0;
    logic              strobe_n, valid, tmo;
    logic [DATA_W-1:0] raw;
    logic [OUT_W-1:0]  sext;

    adc_seq_ctrl #(
        .DATA_W(DATA_W), .OUT_W(OUT_W), .STRB_LOW_CYC(STRB_LOW_CYC),
        .STRB_REL_CYC(STRB_REL_CYC), .CAPT_MIN_CYC(CAPT_MIN_CYC),
        .PERIOD_CYC(PERIOD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .adc_busy_i(busy),
        .adc_data_i(bus), .conv_start_n_o(strobe_n), .sample_valid_o(valid),
        .sample_raw_o(raw), .sample_sext_o(sext), .conv_timeout_o(tmo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Converter stub and port monitor, all at the falling edge
    int                stub_len  = 30;
    logic [DATA_W-1:0] stub_word = '0;
    int                remain    = 0;
    logic              prev_strb = 1'b1;
    logic              prev_val  = 1'b0;
    int falls = 0, valids = 0, errs = 0, restart_viol = 0, dbl_valid = 0;
    int fall_cyc = 0, prev_fall_cyc = 0, rise_cyc = 0, valid_cyc = 0, err_cyc = 0;
    int low_cnt = 0, last_low = 0;
    logic [DATA_W-1:0] got_raw  = '0;
    logic [OUT_W-1:0]  got_sext = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_strb && !strobe_n) begin
                falls++;
                prev_fall_cyc = fall_cyc;
                fall_cyc = cyc;
                if (!busy) restart_viol++;
                else begin
                    busy   = 1'b0;
                    bus    = 14'h2AAA;
                    remain = stub_len;
                end
            end else if (!busy) begin
                remain--;
                if (remain == 0) begin
                    busy     = 1'b1;
                    bus      = stub_word;
                    rise_cyc = cyc;
                end
            end
            if (!strobe_n) low_cnt++;
            else if (low_cnt > 0) begin
                last_low = low_cnt;
                low_cnt  = 0;
            end
            if (valid) begin
                valids++;
                valid_cyc = cyc;
                got_raw   = raw;
                got_sext  = sext;
                if (prev_val) dbl_valid++;
            end
            if (tmo) begin
                errs++;
                err_cyc = cyc;
            end
        end
        prev_strb = strobe_n;
        prev_val  = valid;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_falls(input int target);
        for (int i = 0; i < 1000 && falls < target; i++) step(1);
        check(falls >= target, "wait start strobe", falls, target);
    endtask

    task automatic wait_valids(input int target);
        for (int i = 0; i < 1000 && valids < target; i++) step(1);
        check(valids >= target, "wait sample valid", valids, target);
    endtask

    task automatic drain;
        enable = 1'b0;
        step(300);
    endtask

    task automatic t_reset;
        step(1);
        check(strobe_n == 1'b1, "R1 strobe idle", strobe_n, 1);
        check(valid == 1'b0, "R1 valid low", valid, 0);
        check(tmo == 1'b0, "R1 timeout low", tmo, 0);
    endtask

    task automatic t_disabled;
        step(100);
        check(falls == 0, "R2 no start while disabled", falls, 0);
    endtask

    task automatic t_single_and_period;
        int v0;
        v0        = valids;
        stub_len  = 30;
        stub_word = 14'h1234;
        enable    = 1'b1;
        wait_valids(v0 + 1);
        check(valid_cyc - rise_cyc == CAPT_MIN_CYC + 1, "R5 capture latency",
              valid_cyc - rise_cyc, CAPT_MIN_CYC + 1);
        check(got_raw == 14'h1234, "R5 captured word", got_raw, 14'h1234);
        check(last_low == STRB_LOW_CYC, "R3 strobe low length", last_low, STRB_LOW_CYC);
        wait_falls(2);
        check(fall_cyc - prev_fall_cyc == PERIOD_CYC, "R8 start period",
              fall_cyc - prev_fall_cyc, PERIOD_CYC);
        // R11: drop enable while the second conversion is running
        enable = 1'b0;
        step(200);
        check(valids == v0 + 2, "R11 in-flight sample delivered", valids, v0 + 2);
        check(falls == 2, "R11 no start after disable", falls, 2);
        check(dbl_valid == 0, "R6 valid one cycle", dbl_valid, 0);
    endtask

    task automatic t_sign;
        logic [DATA_W-1:0] w [4];
        logic [OUT_W-1:0]  e [4];
        int v0;
        w[0] = 14'h1FFF; e[0] = 16'h1FFF;
        w[1] = 14'h2000; e[1] = 16'hE000;
        w[2] = 14'h3FFF; e[2] = 16'hFFFF;
        w[3] = 14'h0001; e[3] = 16'h0001;
        v0        = valids;
        stub_word = w[0];
        enable    = 1'b1;
        for (int i = 0; i < 4; i++) begin
            wait_valids(v0 + i + 1);
            if (i < 3) stub_word = w[i+1];
            check(got_raw == w[i], "R5 raw word", got_raw, w[i]);
            check(got_sext == e[i], "R7 sign extension", got_sext, e[i]);
        end
        drain();
        check(dbl_valid == 0, "R6 valid one cycle", dbl_valid, 0);
    endtask

    task automatic t_long;
        int f0;
        f0       = falls;
        stub_len = 50;
        enable   = 1'b1;
        wait_falls(f0 + 2);
        check(fall_cyc - prev_fall_cyc == 50 + CAPT_MIN_CYC + 2, "R9 stretched period",
              fall_cyc - prev_fall_cyc, 50 + CAPT_MIN_CYC + 2);
        drain();
        check(restart_viol == 0, "R4 no start during busy", restart_viol, 0);
    endtask

    task automatic t_timeout;
        int f0, v0, e0;
        f0       = falls;
        v0       = valids;
        e0       = errs;
        stub_len = 200;
        enable   = 1'b1;
        wait_falls(f0 + 1);
        stub_len = 30;
        for (int i = 0; i < 300 && errs == e0; i++) step(1);
        check(errs == e0 + 1, "R10 timeout raised", errs, e0 + 1);
        check(err_cyc - fall_cyc == TIMEOUT_CYC, "R10 timeout cycle",
              err_cyc - fall_cyc, TIMEOUT_CYC);
        for (int i = 0; i < 300 && !busy; i++) step(1);
        check(falls == f0 + 1, "R4 held off while busy low", falls, f0 + 1);
        check(valids == v0, "R10 no valid from timed-out conversion", valids, v0);
        wait_falls(f0 + 2);
        check(fall_cyc - rise_cyc == 3, "R4 start after busy sync", fall_cyc - rise_cyc, 3);
        wait_valids(v0 + 1);
        drain();
        check(errs == e0 + 1, "R10 single timeout pulse", errs, e0 + 1);
        check(valids == v0 + 1, "R10 sampling resumes", valids, v0 + 1);
        check(restart_viol == 0, "R4 no restart", restart_viol, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_single_and_period();
        t_sign();
        t_long();
        t_timeout();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule